// File: doc/BRIEF.md
# Control Pipe Data Toggle Sequencer

This block holds the data toggle bit (DATA0 or DATA1) of a single host-side control pipe. A control transfer runs through three stages in order: SETUP, then an optional data stage (IN or OUT), then a status stage in the direction opposite to the data stage. Before each stage, software loads the stage token. Every token load forces the toggle to a fixed starting value: SETUP starts at DATA0, and IN or OUT starts at DATA1.

After a packet completes with a handshake, the toggle inverts. A multi-packet data stage therefore alternates DATA1, DATA0, DATA1 and so on. On the IN token the block compares the PID toggle bit of each received packet with the expected value. A match is accepted and advances the toggle. A mismatch is rejected, leaves the toggle where it was, and sets a sticky error flag that software clears.

Top module: `ctl_pipe_toggle`

## Requirements
- R1: After reset the token is SETUP (code 0), the toggle is 0, the error flag is 0, and `rx_accept` and `rx_reject` are 0.
- R2: Token codes are 0 for SETUP, 1 for IN and 2 for OUT. A `tok_wr` with code 0 sets the token to SETUP and the toggle to 0 on the next cycle. A `tok_wr` with code 3 is not a load: token and toggle keep their values.
- R3: A `tok_wr` with code 1 or code 2 sets the token to that code and the toggle to 1 on the next cycle.
- R4: A `tx_done` while the token is SETUP or OUT inverts the toggle on the next cycle. A `tx_done` while the token is IN has no effect.
- R5: A `rx_done` while the token is IN and `rx_pid_tgl` equals the toggle inverts the toggle and pulses `rx_accept` for one cycle. Both happen on the next cycle.
- R6: A `rx_done` while the token is IN and `rx_pid_tgl` differs from the toggle leaves the toggle unchanged. On the next cycle it pulses `rx_reject` for one cycle and sets `data_tgl_err`.
- R7: `data_tgl_err` stays set until `err_clr` is high at a clock edge. If a clear and a new mismatch arrive in the same cycle, the flag stays set.
- R8: When a valid token load and a `tx_done` or `rx_done` arrive in the same cycle, the load wins and the strobe is dropped. A `rx_done` under a token other than IN is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_wr | input | 1 | Load strobe for the stage token |
| tok_sel | input | 2 | Token code: 0 SETUP, 1 IN, 2 OUT, 3 reserved |
| tx_done | input | 1 | Host-sent packet completed with handshake |
| rx_done | input | 1 | Data packet received |
| rx_pid_tgl | input | 1 | Toggle bit carried by the received PID |
| err_clr | input | 1 | Clears the toggle error flag |
| cur_tok | output | 2 | Current stage token |
| cur_tgl | output | 1 | Expected or transmitted toggle |
| data_tgl_err | output | 1 | Sticky toggle mismatch flag |
| rx_accept | output | 1 | One-cycle pulse: received packet accepted |
| rx_reject | output | 1 | One-cycle pulse: received packet rejected |

## Verification
The block has no parameters, so the bench builds its only configuration. That configuration covers every combination of token, strobe, PID bit and clear. A directed sequence walks a full transfer with a multi-packet IN data stage and an OUT status stage. It then hits the corner cases:
- the reserved token code;
- a strobe under the wrong token;
- a load colliding with a strobe;
- a clear arriving together with a new mismatch.

A long stretch of random stimulus then runs against the behavioural model.

// File: rtl/ctl_pipe_toggle.sv
module ctl_pipe_toggle (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_wr,
  input  logic [1:0] tok_sel,
  input  logic       tx_done,
  input  logic       rx_done,
  input  logic       rx_pid_tgl,
  input  logic       err_clr,
  output logic [1:0] cur_tok,
  output logic       cur_tgl,
  output logic       data_tgl_err,
  output logic       rx_accept,
  output logic       rx_reject
);
  localparam logic [1:0] TK_SETUP = 2'd0;
  localparam logic [1:0] TK_IN    = 2'd1;
  localparam logic [1:0] TK_OUT   = 2'd2;
  localparam logic [1:0] TK_RSVD  = 2'd3;

  logic load, rx_ok, match, adv;

  assign load  = tok_wr && (tok_sel != TK_RSVD);
  assign rx_ok = !load && rx_done && (cur_tok == TK_IN);
  assign match = (rx_pid_tgl == cur_tgl);
  assign adv   = !load && ((tx_done && cur_tok != TK_IN) || (rx_ok && match));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_tok      <= TK_SETUP;
      cur_tgl      <= 1'b0;
      data_tgl_err <= 1'b0;
      rx_accept    <= 1'b0;
      rx_reject    <= 1'b0;
    end else begin
      if (load) begin
        cur_tok <= tok_sel;
        cur_tgl <= (tok_sel != TK_SETUP);
      end else if (adv) begin
        cur_tgl <= ~cur_tgl;
      end
      rx_accept <= rx_ok && match;
      rx_reject <= rx_ok && !match;
      if (rx_ok && !match)
        data_tgl_err <= 1'b1;
      else if (err_clr)
        data_tgl_err <= 1'b0;
    end
  end

  assert_setup_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_wr && tok_sel == TK_SETUP |=> cur_tgl == 1'b0 && cur_tok == TK_SETUP);

  assert_rsvd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_wr && tok_sel == TK_RSVD && !tx_done && !rx_done |=> $stable(cur_tok) && $stable(cur_tgl));

  assert_inout_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tok_wr && (tok_sel == TK_IN || tok_sel == TK_OUT) |=> cur_tgl == 1'b1);

  assert_tx_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_wr && tx_done && (cur_tok == TK_SETUP || cur_tok == TK_OUT) |=> cur_tgl != $past(cur_tgl));

  assert_rx_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_wr && rx_done && cur_tok == TK_IN && rx_pid_tgl == cur_tgl |=> rx_accept && cur_tgl != $past(cur_tgl));

  assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_wr && rx_done && cur_tok == TK_IN && rx_pid_tgl != cur_tgl |=> rx_reject && data_tgl_err && $stable(cur_tgl));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_tgl_err && !err_clr |=> data_tgl_err);

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_accept, rx_reject}));

  assert_rx_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_tok != TK_IN |=> !rx_accept && !rx_reject);
endmodule

// File: tb/ctl_pipe_toggle_tb.sv
module ctl_pipe_toggle_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_wr = 0, tx_done = 0, rx_done = 0, rx_pid_tgl = 0, err_clr = 0;
  logic [1:0] tok_sel = 0;
  logic [1:0] cur_tok;
  logic cur_tgl, data_tgl_err, rx_accept, rx_reject;

  int checks = 0, fails = 0;
  int m_tok = 0, m_tgl = 0, m_err = 0, m_acc = 0, m_rej = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_pipe_toggle dut_i (
    .clk(clk), .rst_n(rst_n), .tok_wr(tok_wr), .tok_sel(tok_sel),
    .tx_done(tx_done), .rx_done(rx_done), .rx_pid_tgl(rx_pid_tgl), .err_clr(err_clr),
    .cur_tok(cur_tok), .cur_tgl(cur_tgl), .data_tgl_err(data_tgl_err),
    .rx_accept(rx_accept), .rx_reject(rx_reject));

  task automatic compare(string req);
    int got, exp;
    got = {cur_tok, cur_tgl, data_tgl_err, rx_accept, rx_reject};
    exp = {m_tok[1:0], m_tgl[0], m_err[0], m_acc[0], m_rej[0]};
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s t=%0t got tok/tgl/err/acc/rej=%b expected %b",
               req, $time, got[5:0], exp[5:0]);
    end
  endtask

  task automatic model_edge();
    bit ld, rxok, errset;
    ld = tok_wr && tok_sel != 2'd3;
    m_acc = 0; m_rej = 0; errset = 0;
    if (ld) begin
      m_tok = tok_sel;
      m_tgl = (tok_sel == 2'd0) ? 0 : 1;
    end else begin
      if (tx_done && m_tok != 1) m_tgl = 1 - m_tgl;
      rxok = rx_done && m_tok == 1;
      if (rxok) begin
        if (rx_pid_tgl == m_tgl[0]) begin m_tgl = 1 - m_tgl; m_acc = 1; end
        else begin m_rej = 1; errset = 1; end
      end
    end
    if (errset) m_err = 1;
    else if (err_clr) m_err = 0;
  endtask

  task automatic step(string req, bit w, int s, bit tx, bit rx, bit pid, bit clr);
    tok_wr = w; tok_sel = s[1:0]; tx_done = tx; rx_done = rx; rx_pid_tgl = pid; err_clr = clr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    step("R1", 0,0,0,0,0,0);
    step("R4", 0,0,1,0,0,0);   // SETUP packet sent -> 1
    step("R2", 1,0,0,0,0,0);   // reload SETUP -> 0
    step("R4", 0,0,1,0,0,0);
    step("R3", 1,1,0,0,0,0);   // IN data stage -> 1
    step("R5", 0,0,0,1,1,0);   // accept, -> 0
    step("R5", 0,0,0,1,0,0);   // accept, -> 1
    step("R6", 0,0,0,1,0,0);   // mismatch, reject, err
    step("R7", 0,0,0,0,0,0);   // err sticky
    step("R4", 0,0,1,0,0,0);   // tx under IN ignored
    step("R7", 0,0,0,1,0,1);   // clear with new error -> stays
    step("R7", 0,0,0,0,0,1);   // clear
    step("R2", 1,3,0,0,0,0);   // reserved code ignored
    step("R8", 1,2,0,1,0,0);   // load wins over rx
    step("R8", 0,0,0,1,0,0);   // rx under OUT ignored
    step("R4", 0,0,1,0,0,0);   // OUT status -> 0
    step("R8", 1,0,1,0,0,0);   // load wins over tx
    step("R3", 1,2,0,0,0,0);
    step("R3", 1,1,0,0,0,0);
    for (int i = 0; i < 3000; i++)
      step("R8", $urandom_range(0,3) == 0, $urandom_range(0,3), $urandom_range(0,1) == 1,
           $urandom_range(0,1) == 1, $urandom_range(0,1) == 1, $urandom_range(0,5) == 0);
    rst_n = 1'b0;
    @(posedge clk);
    m_tok = 0; m_tgl = 0; m_err = 0; m_acc = 0; m_rej = 0;
    @(negedge clk);
    compare("R1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule